// File: doc/BRIEF.md
# Fixed-Latency Memory Bus Responder

This block is a bus slave that stands in for a slow external memory on a strobe/acknowledge bus. A master raises `stb` with `we` selecting write or read, places a byte address on `addr` and, for writes, a 32-bit word on `wdata`. The responder holds the access for a fixed number of clocks and then gives a one-cycle `ack`. Reads and writes each have their own fixed latency. The defaults are 14 clocks for a read and 6 for a write. These values come from measurements of a real controller, so a system model sees a realistic memory speed.

Storage is a small array of whole 32-bit words, indexed by the word-address bits of `addr`. There are no byte enables, bursts or refresh. If the master drops `stb` before the acknowledge, the access is abandoned and nothing is written.

Top module: `mem_latency_slave`

## Requirements
- R1: After reset, `ack` is low and `rdata` is zero until an access completes.
- R2: A read acknowledges in exactly cycle RD_LAT (default 14). Cycle 1 is the first cycle in which `stb` is high while the block is idle. `ack` is high for that one cycle only.
- R3: A write acknowledges in exactly cycle WR_LAT (default 6), counted the same way, for one cycle.
- R4: During a read's `ack` cycle, `rdata` holds the word most recently written to that index. In every other cycle, `rdata` is zero.
- R5: A write stores `wdata` in the cycle of its `ack`. The word index is `addr[IDXW+1:2]` with IDXW = log2(DEPTH), and `addr[1:0]` is ignored.
- R6: Direction and index are taken in cycle 1. Changes to `we` or `addr` later in the same access have no effect.
- R7: If `stb` is low in any cycle up to and including the would-be `ack` cycle, no `ack` is given and no word is written. The block returns to idle.
- R8: If `stb` stays high in the cycle after an `ack`, that cycle is cycle 1 of a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb | input | 1 | Access request strobe from the master |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address; word index is bits IDXW+1..2 |
| wdata | input | DATA_W | Write word |
| rdata | output | DATA_W | Read word, valid in the read ack cycle |
| ack | output | 1 | One-cycle completion pulse |

## Verification
Two functions can meet in one cycle: the completion of an access, and its abandonment when `stb` falls. This happens when the master drops `stb` in exactly the cycle that would carry `ack`. The bench provokes this for both reads and writes. It judges the result by seeing `ack` stay low, and by reading the target word back afterwards to show that it is unchanged. A second overlap is the `ack` of one access followed directly by cycle 1 of the next. The bench drives this back-to-back with `stb` held high and checks the full latency of the second access.

// File: rtl/mem_latency_slave.sv
module mem_latency_slave #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH) + 2,
  parameter int RD_LAT = 14,
  parameter int WR_LAT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ack
);
  localparam int IDXW = $clog2(DEPTH);
  localparam int MAXL = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
  localparam int CNTW = $clog2(MAXL + 1);

  logic              busy;
  logic              op_we;
  logic [IDXW-1:0]   op_idx;
  logic [CNTW-1:0]   cnt;
  logic [DATA_W-1:0] mem [DEPTH];

  wire [IDXW-1:0] idx_in = addr[IDXW+1:2];
  wire unused_lsb = &{1'b0, addr[1:0]};
  wire [CNTW-1:0] last = op_we ? CNTW'(WR_LAT - 1) : CNTW'(RD_LAT - 1);

  assign ack   = busy && stb && (cnt == last);
  assign rdata = (ack && !op_we) ? mem[op_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      op_we  <= 1'b0;
      op_idx <= '0;
      cnt    <= '0;
    end else if (!busy) begin
      if (stb) begin
        busy   <= 1'b1;
        cnt    <= CNTW'(1);
        op_we  <= we;
        op_idx <= idx_in;
      end
    end else if (!stb || ack) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ack && op_we) mem[op_idx] <= wdata;
  end
endmodule

// File: rtl/mem_latency_slave_chk.sv
module mem_latency_slave_chk #(
  parameter int DATA_W = 32,
  parameter int RD_LAT = 14,
  parameter int WR_LAT = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stb,
  input logic              we,
  input logic              ack,
  input logic [DATA_W-1:0] rdata
);
  logic [15:0] c;
  logic        first_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c        <= '0;
      first_we <= 1'b0;
    end else begin
      c <= (stb && !ack) ? c + 16'd1 : 16'd0;
      if (c == 16'd0 && stb) first_we <= we;
    end
  end

  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);
  p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !first_we) |-> (c == 16'(RD_LAT - 1)));
  p_wr_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && first_we) |-> (c == 16'(WR_LAT - 1)));
  p_rdata_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (rdata == '0));
  p_ack_needs_stb_r7: assert property (@(posedge clk) disable iff (!rst_n) ack |-> stb);
endmodule

bind mem_latency_slave mem_latency_slave_chk #(
  .DATA_W(DATA_W), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)
) u_chk (.*);

// File: tb/mem_latency_slave_test.sv
module mem_latency_slave_test;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH) + 2;
  localparam int RDL = 14;
  localparam int WRL = 6;

  logic clk = 0, rst_n = 0, stb = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic ack;
  int total = 0, bad = 0;
  logic [31:0] model [DEPTH];

  always #4 clk = ~clk;

  mem_latency_slave #(.DATA_W(32), .DEPTH(DEPTH), .RD_LAT(RDL), .WR_LAT(WRL)) uut (
    .clk(clk), .rst_n(rst_n), .stb(stb), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ack(ack));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input bit w, input int idx, input logic [31:0] d, input bit keep,
                     output int lat, output logic [31:0] q);
    stb = 1; we = w; addr = AW'(idx * 4 + (idx % 4)); wdata = d; lat = 0; q = '0;
    forever begin
      lat++;
      #1;
      if (ack) begin q = rdata; break; end
      if (lat > 40) break;
      @(negedge clk);
    end
    @(negedge clk);
    if (!keep) begin stb = 0; #1; chk("R2 ack one cycle", {31'd0, ack}, 32'd0); @(negedge clk); end
  endtask

  task automatic abort_at(input bit w, input int idx, input int k, input string req);
    stb = 1; we = w; addr = AW'(idx * 4); wdata = 32'hDEAD_BEEF;
    for (int i = 1; i < k; i++) @(negedge clk);
    stb = 0;
    for (int i = 0; i < RDL + 2; i++) begin
      #1;
      chk(req, {31'd0, ack}, 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] q;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ack reset", {31'd0, ack}, 32'd0);
    chk("R1 rdata reset", rdata, 32'd0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101) ^ 32'(i << 20);
      acc(1, i, model[i], 0, lat, q);
      chk("R3 write latency", 32'(lat), 32'(WRL));
      chk("R4 rdata zero on write ack", q, 32'd0);
    end
    for (int i = DEPTH - 1; i >= 0; i--) begin
      acc(0, i, 32'h0, 0, lat, q);
      chk("R2 read latency", 32'(lat), 32'(RDL));
      chk("R4 R5 read data", q, model[i]);
    end

    for (int i = 0; i < DEPTH; i += 2) begin
      model[i] = ~model[i];
      acc(1, i, model[i], 1, lat, q);
      chk("R3 write latency b2b", 32'(lat), 32'(WRL));
      acc(0, i + 1, 32'h0, 1, lat, q);
      chk("R8 back-to-back read latency", 32'(lat), 32'(RDL));
      chk("R8 back-to-back read data", q, model[i + 1]);
      acc(0, i, 32'h0, 1, lat, q);
      chk("R8 back-to-back readback", q, model[i]);
    end
    stb = 0;
    @(negedge clk);

    stb = 1; we = 1; addr = AW'(3 * 4); wdata = 32'h1234_5678;
    @(negedge clk);
    @(negedge clk);
    we = 0; addr = AW'(5 * 4);
    lat = 2;
    forever begin
      lat++;
      @(negedge clk);
      #1;
      if (ack || lat > 40) break;
    end
    chk("R6 latency follows first direction", 32'(lat + 1), 32'(WRL));
    @(negedge clk); stb = 0; @(negedge clk);
    model[3] = 32'h1234_5678;
    acc(0, 3, 0, 0, lat, q);
    chk("R6 first index written", q, model[3]);
    acc(0, 5, 0, 0, lat, q);
    chk("R6 later index untouched", q, model[5]);

    abort_at(1, 7, 3, "R7 early write abort no ack");
    acc(0, 7, 0, 0, lat, q);
    chk("R7 early write abort no store", q, model[7]);
    abort_at(1, 8, WRL, "R7 final-cycle write abort no ack");
    acc(0, 8, 0, 0, lat, q);
    chk("R7 final-cycle write abort no store", q, model[8]);
    abort_at(0, 9, RDL, "R7 final-cycle read abort no ack");
    acc(0, 9, 0, 0, lat, q);
    chk("R7 read after abort latency", 32'(lat), 32'(RDL));
    chk("R7 read after abort data", q, model[9]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule